// File: doc/BRIEF.md
# Character Cell Fetch Sequencer

This block drives the video memory address bus of a text-mode display, one fetch per clock step. A display window is opened by a chain of latches. A vertical latch arms when the programmed first row matches half of the previous step's line count. A horizontal latch then fires when the cycle count reaches the programmed first column. A short per-line pipeline follows: it reloads the screen-matrix pointer, captures the column count and the row count, and finally starts the column counter. Within the active columns the block alternates between two kinds of fetch. Even steps read a character code from the screen matrix. Odd steps read one byte of that character's glyph from the character generator.

The step timing (cycle count, line count and the line and field wrap strobes) comes from an external timing generator. The fetched byte and a parallel 4-bit colour nibble come back from memory combinationally against the registered address. The code and colour returned by each matrix fetch are latched for the pixel stage. Settings are written through a small write-only register port. When no fetch is due, the bus parks on a fixed idle address.

Top module: `char_fetch_seq`

## Requirements
- R1: While rst_ni is low, fetch_addr_o is 0x1C, fetch_active_o is 0, char_code_o is 0 and char_colour_o is 0.
- R2: The vertical latch sets in a step where first_row equals the previous step's vcnt_i shifted right by one, and it stays set until a field wrap. The horizontal latch sets in a step where the vertical latch is set and hcnt_i equals first_col, and it is cleared by each line wrap.
- R3: If the horizontal latch sets in the step with hcnt_i = h, the first fetch is made in the step with hcnt_i = h+3, and 2×columns consecutive fetches follow. A fetch burst always has at least two steps.
- R4: An even fetch (column counter even) outputs matrix_base + pointer and then advances the pointer by one.
- R5: An odd fetch outputs glyph_base + code×8 + glyph_line, where code is the byte returned by the preceding even fetch. Every address is truncated to 14 bits.
- R6: In any step without a fetch, the address is 0x1C and fetch_active_o is 0.
- R7: At each line wrap with the horizontal latch set, the glyph line increments. It wraps to 0 after 7 (or after 15 when tall), and on a wrap the text row advances. An even fetch made on the last glyph line stores the advanced pointer as the next row's base. Each line reloads the pointer from that base, so row r, column c reads matrix_base + r×columns + c.
- R8: The row count is captured once per field, two steps after the window first opens. A later write to the row setting takes effect only in the next field. Rows at or beyond the captured count make no fetches.
- R9: A field wrap clears the text row, the glyph line, the row base and the vertical latch, and it invalidates the captured row count. Every field therefore restarts at matrix_base.
- R10: Register map, with writes at cfg_addr_i. Address 0: bits 6:0 give first_col. Address 1: bits 7:0 give first_row. Address 2: bits 6:0 give columns, and bit 7 gives matrix_base bit 9. Address 3: bits 6:1 give rows, and bit 0 selects tall (16-line) glyphs, which use code×16 in R5. Address 5: bits 7:4 give matrix_base bits 13:10, and bits 3:0 give glyph_base bits 13:10. All other base bits are 0, and other addresses are ignored.
- R11: The clock edge after an even fetch step latches rd_data_i into char_code_o and rd_colour_i into char_colour_o. At no other time do they change.
- R12: The address and fetch_active_o for a step are registered, and they appear after the clock edge that samples that step's hcnt_i and vcnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 8 | Register write data |
| hcnt_i | input | 7 | Cycle count within the line for this step |
| vcnt_i | input | 9 | Line count for this step |
| line_wrap_i | input | 1 | Step is the first of a new line |
| field_wrap_i | input | 1 | Step is the first of a new field (with line_wrap_i) |
| rd_data_i | input | 8 | Byte read at fetch_addr_o |
| rd_colour_i | input | 4 | Colour nibble read alongside rd_data_i |
| fetch_addr_o | output | 14 | Video memory address |
| fetch_active_o | output | 1 | A matrix or glyph fetch is in progress |
| char_code_o | output | 8 | Latched character code |
| char_colour_o | output | 4 | Latched colour nibble |

## Verification
The address and the active flag for a step appear one edge after the step's counters are driven. The bench therefore drives each step at a falling edge and compares that step's expected address and flag at the next falling edge. The latched code and colour change on the edge after a matrix fetch, so they are compared during the following glyph fetch step against the memory model's value at the preceding matrix address. A row-count write made mid-field only changes expectations from the next field onward.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int ADDR_W   = 14;
  localparam int DATA_W   = 8;
  localparam int COLOUR_W = 4;
  localparam int HCNT_W   = 7;
  localparam int VCNT_W   = 9;
  localparam int COLS_W   = 7;
  localparam int ROWS_W   = 6;
  localparam int GLINE_W  = 4;
  localparam int TROW_W   = 8;
  localparam int HI_W     = 4;
  localparam int STEP_W   = 3;
  localparam int CCNT_W   = COLS_W + 1;
  localparam logic [ADDR_W-1:0] IDLE_ADDR = ADDR_W'(8'h1C);

  typedef struct packed {
    logic [HCNT_W-1:0]  first_col;
    logic [DATA_W-1:0]  first_row;
    logic [COLS_W-1:0]  cols;
    logic [ROWS_W-1:0]  rows;
    logic               tall;
    logic               mtx_b9;
    logic [HI_W-1:0]    mtx_hi;
    logic [HI_W-1:0]    gly_hi;
  } cfg_t;
endpackage

// File: rtl/cfs_regs.sv
module cfs_regs
  import cfs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output cfg_t        cfg_o
);
  cfg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (we_i) begin
      case (addr_i)
        4'h0: q.first_col <= wdata_i[HCNT_W-1:0];
        4'h1: q.first_row <= wdata_i;
        4'h2: begin
          q.cols   <= wdata_i[COLS_W-1:0];
          q.mtx_b9 <= wdata_i[7];
        end
        4'h3: begin
          q.rows <= wdata_i[ROWS_W:1];
          q.tall <= wdata_i[0];
        end
        4'h5: begin
          q.mtx_hi <= wdata_i[7:4];
          q.gly_hi <= wdata_i[3:0];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = q;
endmodule

// File: rtl/cfs_window.sv
module cfs_window
  import cfs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HCNT_W-1:0]  first_col_i,
  input  logic [DATA_W-1:0]  first_row_i,
  input  logic [COLS_W-1:0]  cols_i,
  input  logic [ROWS_W-1:0]  rows_i,
  input  logic               tall_i,
  input  logic [HCNT_W-1:0]  hcnt_i,
  input  logic [VCNT_W-1:0]  vcnt_i,
  input  logic               line_wrap_i,
  input  logic               field_wrap_i,
  output logic               fetch_o,
  output logic               odd_o,
  output logic               load_ptr_o,
  output logic [GLINE_W-1:0] gline_o,
  output logic               last_gline_o
);
  localparam logic [STEP_W-1:0] STEP_MAX = '1;

  logic               vl_q, hl_q, idle_q, rows_ok_q, act_q;
  logic [STEP_W-1:0]  step_q;
  logic [COLS_W-1:0]  cols_q;
  logic [ROWS_W-1:0]  rows_q;
  logic [CCNT_W-1:0]  col_q;
  logic [GLINE_W-1:0] gline_q;
  logic [TROW_W-1:0]  row_q;
  logic [VCNT_W-1:0]  prev_v_q;

  logic               vl_n, hl_n, idle_n, rows_ok_n, act_n, end_line, gl_wrap;
  logic [STEP_W-1:0]  step_n;
  logic [COLS_W-1:0]  cols_n;
  logic [ROWS_W-1:0]  rows_n;
  logic [CCNT_W-1:0]  col_n, col_nx;
  logic [GLINE_W-1:0] gline_n;
  logic [TROW_W-1:0]  row_n;
  logic               fetch;

  always_comb begin
    end_line = line_wrap_i && hl_q;
    gl_wrap  = tall_i ? (gline_q == GLINE_W'(15)) : (gline_q == GLINE_W'(7));
    gline_n  = gline_q;
    row_n    = row_q;
    if (end_line) begin
      if (gl_wrap) begin
        gline_n = '0;
        row_n   = row_q + 1'b1;
      end else gline_n = gline_q + 1'b1;
    end
    vl_n      = vl_q;
    rows_ok_n = rows_ok_q;
    if (field_wrap_i) begin
      gline_n   = '0;
      row_n     = '0;
      vl_n      = 1'b0;
      rows_ok_n = 1'b0;
    end
    // compare against half the previous step's line count
    vl_n = vl_n | ({1'b0, first_row_i} == (prev_v_q >> 1));
    hl_n = (line_wrap_i ? 1'b0 : hl_q) | (vl_n && (hcnt_i == first_col_i));

    idle_n   = end_line ? 1'b1 : idle_q;
    cols_n   = end_line ? '0 : cols_q;
    act_n    = end_line ? 1'b0 : act_q;
    rows_n   = rows_q;
    col_n    = col_q;
    step_n   = step_q;
    load_ptr_o = 1'b0;
    if (!idle_n) begin
      step_n = (step_q == STEP_MAX) ? step_q : step_q + 1'b1;
      case (step_n)
        STEP_W'(1): cols_n = cols_i;
        STEP_W'(2): if (!rows_ok_n) begin
          rows_n    = rows_i;
          rows_ok_n = 1'b1;
        end
        STEP_W'(3): if (rows_ok_n && (row_n < TROW_W'(rows_n))) begin
          act_n = 1'b1;
          col_n = '0;
        end
        default: ;
      endcase
    end else if (hl_n) begin
      idle_n     = 1'b0;
      step_n     = '0;
      load_ptr_o = 1'b1;
    end

    fetch  = act_n && (col_n < {cols_n, 1'b0});
    col_nx = fetch ? col_n + 1'b1 : col_n;
  end

  assign fetch_o      = fetch;
  assign odd_o        = col_n[0];
  assign gline_o      = gline_n;
  assign last_gline_o = tall_i ? (gline_n == GLINE_W'(15)) : (gline_n == GLINE_W'(7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q <= 1'b0; hl_q <= 1'b0; idle_q <= 1'b1; rows_ok_q <= 1'b0; act_q <= 1'b0;
      step_q <= '0; cols_q <= '0; rows_q <= '0; col_q <= '0;
      gline_q <= '0; row_q <= '0; prev_v_q <= '0;
    end else begin
      vl_q <= vl_n; hl_q <= hl_n; idle_q <= idle_n; rows_ok_q <= rows_ok_n; act_q <= act_n;
      step_q <= step_n; cols_q <= cols_n; rows_q <= rows_n; col_q <= col_nx;
      gline_q <= gline_n; row_q <= row_n; prev_v_q <= vcnt_i;
    end
  end
endmodule

// File: rtl/cfs_addr.sv
module cfs_addr
  import cfs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mtx_b9_i,
  input  logic [HI_W-1:0]     mtx_hi_i,
  input  logic [HI_W-1:0]     gly_hi_i,
  input  logic                tall_i,
  input  logic                field_wrap_i,
  input  logic                load_ptr_i,
  input  logic                fetch_i,
  input  logic                odd_i,
  input  logic [GLINE_W-1:0]  gline_i,
  input  logic                last_gline_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [COLOUR_W-1:0] colour_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                active_o,
  output logic [DATA_W-1:0]   code_o,
  output logic [COLOUR_W-1:0] colour_o
);
  logic [ADDR_W-1:0]   ptr_q, base_q, addr_q;
  logic [ADDR_W-1:0]   ptr_n, base_n, addr_n, base0, ptr1, ptr_inc;
  logic [ADDR_W-1:0]   mbase, gbase, goff;
  logic                act_q, prev_even_q;
  logic [DATA_W-1:0]   code_q;
  logic [COLOUR_W-1:0] colour_q;

  always_comb begin
    mbase   = {mtx_hi_i, mtx_b9_i, 9'd0};
    gbase   = {gly_hi_i, 10'd0};
    goff    = tall_i ? {2'b0, data_i, 4'b0} : {3'b0, data_i, 3'b0};
    base0   = field_wrap_i ? '0 : base_q;
    ptr1    = load_ptr_i ? base0 : ptr_q;
    ptr_inc = ptr1 + 1'b1;
    ptr_n   = ptr1;
    base_n  = base0;
    addr_n  = IDLE_ADDR;
    if (fetch_i) begin
      if (odd_i) begin
        // data_i carries the code returned for the previous (even) step
        addr_n = gbase + goff + ADDR_W'(gline_i);
      end else begin
        addr_n = mbase + ptr1;
        ptr_n  = ptr_inc;
        if (last_gline_i) base_n = ptr_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; base_q <= '0; addr_q <= IDLE_ADDR; act_q <= 1'b0;
      prev_even_q <= 1'b0; code_q <= '0; colour_q <= '0;
    end else begin
      ptr_q       <= ptr_n;
      base_q      <= base_n;
      addr_q      <= addr_n;
      act_q       <= fetch_i;
      prev_even_q <= fetch_i && !odd_i;
      if (prev_even_q) begin
        code_q   <= data_i;
        colour_q <= colour_i;
      end
    end
  end

  assign addr_o   = addr_q;
  assign active_o = act_q;
  assign code_o   = code_q;
  assign colour_o = colour_q;
endmodule

// File: rtl/char_fetch_seq.sv
module char_fetch_seq
  import cfs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [3:0]          cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  input  logic [HCNT_W-1:0]   hcnt_i,
  input  logic [VCNT_W-1:0]   vcnt_i,
  input  logic                line_wrap_i,
  input  logic                field_wrap_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic [COLOUR_W-1:0] rd_colour_i,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  output logic                fetch_active_o,
  output logic [DATA_W-1:0]   char_code_o,
  output logic [COLOUR_W-1:0] char_colour_o
);
  cfg_t               cfg;
  logic               fetch, odd, load_ptr, last_gline;
  logic [GLINE_W-1:0] gline;

  cfs_regs u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  cfs_window u_win (
    .clk_i, .rst_ni,
    .first_col_i(cfg.first_col), .first_row_i(cfg.first_row), .cols_i(cfg.cols),
    .rows_i(cfg.rows), .tall_i(cfg.tall),
    .hcnt_i, .vcnt_i, .line_wrap_i, .field_wrap_i,
    .fetch_o(fetch), .odd_o(odd), .load_ptr_o(load_ptr),
    .gline_o(gline), .last_gline_o(last_gline)
  );

  cfs_addr u_addr (
    .clk_i, .rst_ni,
    .mtx_b9_i(cfg.mtx_b9), .mtx_hi_i(cfg.mtx_hi), .gly_hi_i(cfg.gly_hi), .tall_i(cfg.tall),
    .field_wrap_i, .load_ptr_i(load_ptr), .fetch_i(fetch), .odd_i(odd),
    .gline_i(gline), .last_gline_i(last_gline),
    .data_i(rd_data_i), .colour_i(rd_colour_i),
    .addr_o(fetch_addr_o), .active_o(fetch_active_o),
    .code_o(char_code_o), .colour_o(char_colour_o)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker
  import cfs_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                line_wrap_i,
  input logic                field_wrap_i,
  input logic [ADDR_W-1:0]   fetch_addr_o,
  input logic                fetch_active_o,
  input logic [DATA_W-1:0]   char_code_o
);
  assert_idle_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_active_o |-> fetch_addr_o == IDLE_ADDR);

  assert_code_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fetch_active_o) |-> $stable(char_code_o));

  assert_line_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_wrap_i |=> !fetch_active_o);

  assert_field_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_wrap_i |=> !fetch_active_o);

  assert_burst_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_active_o) |=> fetch_active_o);
endmodule

bind char_fetch_seq cfs_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_wrap_i(line_wrap_i), .field_wrap_i(field_wrap_i),
  .fetch_addr_o(fetch_addr_o), .fetch_active_o(fetch_active_o), .char_code_o(char_code_o)
);

// File: tb/sim_char_fetch_seq.sv
`timescale 1ns/1ps
module sim_char_fetch_seq;
  localparam int LINE_LEN = 20;
  localparam int LINES    = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [6:0]  hcnt = 7'd127;
  logic [8:0]  vcnt = '0;
  logic        lw = 1'b0, fw = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  rd_colour;
  logic [13:0] fetch_addr;
  logic        fetch_active;
  logic [7:0]  char_code;
  logic [3:0]  char_colour;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem8(input logic [13:0] a);
    return (a[7:0] * 8'd7) ^ 8'hA5;
  endfunction
  function automatic logic [3:0] col4(input logic [13:0] a);
    return a[3:0] ^ 4'h9;
  endfunction

  assign rd_data   = mem8(fetch_addr);
  assign rd_colour = col4(fetch_addr);

  char_fetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .line_wrap_i(lw), .field_wrap_i(fw),
    .rd_data_i(rd_data), .rd_colour_i(rd_colour),
    .fetch_addr_o(fetch_addr), .fetch_active_o(fetch_active),
    .char_code_o(char_code), .char_colour_o(char_colour)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // current configuration, as the bench understands it
  int fc, fr, ncol, hgt;
  logic [13:0] mb, gb;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hcnt = 7'd127; vcnt = '0; lw = 1'b0; fw = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs whole fields; rows_f0/rows_f1 are the row counts expected per field
  task automatic run(input int rows_f0, input int rows_f1, input bit mid_write);
    bit          have = 1'b0;
    string       tag;
    logic [13:0] e_addr, ea;
    int          e_act, e_code, e_col;
    bit          e_chk_code = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < LINES; v++) begin
        for (int h = 0; h < LINE_LEN; h++) begin
          @(negedge clk);
          if (have) begin
            chk({tag, " addr"}, int'(fetch_addr), int'(e_addr));
            chk((e_act != 0) ? "R3 active" : "R12 active", int'(fetch_active), e_act);
            if (e_chk_code) begin
              chk("R11 code", int'(char_code), e_code);
              chk("R11 colour", int'(char_colour), e_col);
            end
          end
          // R8: mid-field row-count write (rows=1, short glyphs)
          cfg_we = mid_write && f == 0 && v == 10 && h == 15;
          cfg_addr = 4'h3; cfg_wdata = 8'h02;
          hcnt = 7'(h); vcnt = 9'(v); lw = (h == 0); fw = (h == 0 && v == 0);
          begin
            int d, k, rows, r, g, c;
            rows = (f == 0) ? rows_f0 : rows_f1;
            d = v - 2 * fr;
            k = h - (fc + 3);
            e_chk_code = 1'b0;
            e_act = (d >= 0 && (d / hgt) < rows && k >= 0 && k < 2 * ncol) ? 1 : 0;
            if (e_act != 0) begin
              r = d / hgt; g = d % hgt; c = k / 2;
              ea = 14'((int'(mb) + r * ncol + c) & 'h3FFF);
              if (k % 2 == 0) begin
                e_addr = ea;
                tag = (d == 0 && k == 0) ? "R2" : (f == 1) ? "R9" : (r > 0) ? "R7" : "R4";
              end else begin
                e_addr = 14'((int'(gb) + int'(mem8(ea)) * hgt + g) & 'h3FFF);
                e_chk_code = 1'b1; e_code = int'(mem8(ea)); e_col = int'(col4(ea));
                tag = (hgt == 16) ? "R10" : "R5";
              end
            end else begin
              e_addr = 14'h1C;
              tag = (d >= 0 && k >= 0 && k < 2 * ncol) ? "R8" : "R6";
            end
          end
          have = 1'b1;
        end
      end
    end
    @(negedge clk);
    chk({tag, " addr"}, int'(fetch_addr), int'(e_addr));
    chk("R12 active", int'(fetch_active), e_act);
    cfg_we = 1'b0;
  endtask

  initial begin
    #3;
    chk("R1 addr", int'(fetch_addr), 'h1C);
    chk("R1 active", int'(fetch_active), 0);
    chk("R1 code", int'(char_code), 0);
    chk("R1 colour", int'(char_colour), 0);
    #10 rst_n = 1'b1;

    // config A: first col 2, first row 1, 3 cols, 2 rows, 8-line glyphs
    wr(4'h0, 8'h82); wr(4'h1, 8'h01); wr(4'h2, 8'h83); wr(4'h3, 8'h04);
    wr(4'h5, 8'h32); wr(4'h4, 8'hFF); wr(4'hA, 8'h55);
    fc = 2; fr = 1; ncol = 3; hgt = 8; mb = 14'h0E00; gb = 14'h0800;
    run(2, 1, 1'b1);

    // config B: first col 3, first row 2, 3 cols, 2 rows, 16-line glyphs, glyph base near top
    wr(4'h0, 8'h03); wr(4'h1, 8'h02); wr(4'h2, 8'h03); wr(4'h3, 8'h05); wr(4'h5, 8'h1F);
    fc = 3; fr = 2; ncol = 3; hgt = 16; mb = 14'h0400; gb = 14'h3C00;
    run(2, 2, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule